// File: doc/BRIEF.md
# Channel-Gain Scan List Sequencer

This block sits between a conversion pacer and an analog front end. It holds a list in which each entry names an input channel and a 2-bit gain code, in any order and with repeats. Each time the converter is asked for a sample, the block drives the multiplexer select and gain select of the current entry and moves on to the next one. Channel and gain therefore change on every sample without any host action and without losing throughput.

The host fills the list and sets the index of the last valid entry through a simple write port, and only while the scan is stopped. A start strobe arms the scan at entry 0 and a stop strobe halts it. While a scan runs, the block ignores list and length writes and flags each one. Alongside the selects, the block reports the index of the presented entry and a one-cycle end-of-scan marker. It also gives the gain factor that the code stands for, from one of two gain sets chosen by a parameter.

Top module: `scan_list_seq`

## Requirements
- R1: While reset is high and in the cycle after it, `mux_sel`, `gain_sel` and `entry_idx` are 0, and `scan_end`, `running` and `wr_reject` are low.
- R2: When `wr_en` is high while the scan is stopped, the entry at `wr_addr` takes `wr_chan` (4 bits, channel 0..15) and `wr_gain` (2 bits). A later scan presents those values for that index.
- R3: A conversion strobe (`conv_req` high while running, with no `start`) in cycle k makes `mux_sel`, `gain_sel` and `entry_idx` show the entry at the read pointer from cycle k+1.
- R4: If no conversion strobe is accepted, `mux_sel`, `gain_sel` and `entry_idx` keep their values.
- R5: Each accepted strobe advances the pointer by one. After the entry whose index equals the stored last index, the pointer returns to 0. A last index of 0 gives a one-entry list.
- R6: `scan_end` is high for exactly the cycle in which the presented entry is the last one. It is low in the cycle after, unless that cycle also presents the last entry.
- R7: `start` sets `running` in the next cycle and moves the pointer to entry 0. It also works during a running scan. A strobe in the same cycle as `start` is dropped and leaves the outputs unchanged.
- R8: List writes and length writes made while `running` is high change nothing. Each one raises `wr_reject` for the next cycle. Writes made while stopped never raise it.
- R9: `conv_req` while stopped changes no output.
- R10: `gain_mult` decodes `gain_sel`. With `LOW_RANGE`=0, codes 0,1,2,3 give 1,2,4,8. With `LOW_RANGE`=1, codes 0,1,2,3 give 1,10,100,500.
- R11: Entries are independent. One channel may appear at several indices with different gain codes, and each index presents its own pair.
- R12: `stop` clears `running` in the next cycle and leaves the select outputs holding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write one list entry |
| wr_addr | input | AW | Index of the entry to write |
| wr_chan | input | 4 | Channel number to store |
| wr_gain | input | 2 | Gain code to store |
| len_we | input | 1 | Write the last-entry index |
| len_last | input | AW | Index of the last valid entry |
| start | input | 1 | Arm the scan at entry 0 |
| stop | input | 1 | Halt the scan |
| conv_req | input | 1 | Conversion strobe |
| running | output | 1 | Scan is armed |
| mux_sel | output | 4 | Channel select to the multiplexer |
| gain_sel | output | 2 | Gain code to the amplifier |
| gain_mult | output | 10 | Gain factor of the presented code |
| entry_idx | output | AW | Index of the presented entry |
| scan_end | output | 1 | Presented entry is the last one |
| wr_reject | output | 1 | A write was refused during a scan |

## Verification
A read pointer that slips or wraps at the wrong index shows up at `entry_idx` and `mux_sel` one cycle after the next strobe, so each strobe in the bench is followed by an index and content check. A corrupted last-index register moves the `scan_end` pulse and the wrap point, and this appears within one scan of the list. A write that gets through during a run only shows up in a later pass over the list. For that reason the bench stops the scan, rearms it and walks the whole list again.

// File: rtl/scan_list_pkg.sv
package scan_list_pkg;

    localparam int CHAN_W  = 4;
    localparam int GCODE_W = 2;
    localparam int GMULT_W = 10;

    typedef logic [GCODE_W-1:0] gcode_t;

    typedef struct packed {
        logic [CHAN_W-1:0] chan;
        gcode_t            gain;
    } scan_entry_t;

    function automatic logic [GMULT_W-1:0] gain_factor(input logic low_range, input gcode_t code);
        logic [GMULT_W-1:0] f;
        if (low_range) begin
            case (code)
                2'd0:    f = 10'd1;
                2'd1:    f = 10'd10;
                2'd2:    f = 10'd100;
                default: f = 10'd500;
            endcase
        end else begin
            f = 10'd1 << code;
        end
        return f;
    endfunction

endpackage

// File: rtl/scan_list_mem.sv
module scan_list_mem
    import scan_list_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        we,
    input  logic [AW-1:0] waddr,
    input  scan_entry_t wdata,
    input  logic        re,
    input  logic [AW-1:0] raddr,
    output scan_entry_t rdata
);

    scan_entry_t store [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            store[waddr] <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= '0;
        end else if (re) begin
            rdata <= store[raddr];
        end
    end

endmodule

// File: rtl/scan_list_ctrl.sv
module scan_list_ctrl #(
    parameter int DEPTH = 64,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          stop,
    input  logic          conv_req,
    input  logic          wr_en,
    input  logic          len_we,
    input  logic [AW-1:0] len_val,
    output logic          running,
    output logic          accept,
    output logic          mem_we,
    output logic [AW-1:0] rd_ptr,
    output logic [AW-1:0] idx_q,
    output logic          end_q,
    output logic          reject
);

    localparam logic [AW:0]   LAST_MAX = (AW+1)'(DEPTH - 1);

    logic [AW-1:0] last_q;
    logic          at_last;

    assign accept  = running && conv_req && !start;
    assign mem_we  = wr_en && !running;
    assign at_last = (rd_ptr == last_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            running <= 1'b0;
            rd_ptr  <= '0;
            last_q  <= '0;
            idx_q   <= '0;
            end_q   <= 1'b0;
            reject  <= 1'b0;
        end else begin
            reject <= running && (wr_en || len_we);
            end_q  <= accept && at_last;
            if (accept) begin
                idx_q <= rd_ptr;
            end
            if (start) begin
                running <= 1'b1;
            end else if (stop) begin
                running <= 1'b0;
            end
            if (start) begin
                rd_ptr <= '0;
            end else if (accept) begin
                rd_ptr <= at_last ? '0 : rd_ptr + 1'b1;
            end
            if (len_we && !running) begin
                last_q <= ({1'b0, len_val} > LAST_MAX) ? LAST_MAX[AW-1:0] : len_val;
            end
        end
    end

endmodule

// File: rtl/scan_list_seq.sv
module scan_list_seq
    import scan_list_pkg::*;
#(
    parameter int   LIST_DEPTH = 64,
    parameter logic LOW_RANGE  = 1'b0,
    localparam int  AW         = (LIST_DEPTH > 1) ? $clog2(LIST_DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [3:0]    wr_chan,
    input  logic [1:0]    wr_gain,
    input  logic          len_we,
    input  logic [AW-1:0] len_last,
    input  logic          start,
    input  logic          stop,
    input  logic          conv_req,
    output logic          running,
    output logic [3:0]    mux_sel,
    output logic [1:0]    gain_sel,
    output logic [9:0]    gain_mult,
    output logic [AW-1:0] entry_idx,
    output logic          scan_end,
    output logic          wr_reject
);

    logic          accept;
    logic          mem_we;
    logic [AW-1:0] rd_ptr;
    scan_entry_t   wentry;
    scan_entry_t   shown;

    assign wentry.chan = wr_chan;
    assign wentry.gain = wr_gain;

    scan_list_ctrl #(.DEPTH(LIST_DEPTH)) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .stop     (stop),
        .conv_req (conv_req),
        .wr_en    (wr_en),
        .len_we   (len_we),
        .len_val  (len_last),
        .running  (running),
        .accept   (accept),
        .mem_we   (mem_we),
        .rd_ptr   (rd_ptr),
        .idx_q    (entry_idx),
        .end_q    (scan_end),
        .reject   (wr_reject)
    );

    scan_list_mem #(.DEPTH(LIST_DEPTH)) u_mem (
        .clk   (clk),
        .rst   (rst),
        .we    (mem_we),
        .waddr (wr_addr),
        .wdata (wentry),
        .re    (accept),
        .raddr (rd_ptr),
        .rdata (shown)
    );

    assign mux_sel   = shown.chan;
    assign gain_sel  = shown.gain;
    assign gain_mult = gain_factor(LOW_RANGE, shown.gain);

endmodule

// File: rtl/scan_list_seq_chk.sv
module scan_list_seq_chk #(
    parameter int AW = 6
) (
    input logic          clk,
    input logic          rst,
    input logic          wr_en,
    input logic          len_we,
    input logic          start,
    input logic          conv_req,
    input logic          running,
    input logic [3:0]    mux_sel,
    input logic [1:0]    gain_sel,
    input logic [9:0]    gain_mult,
    input logic [AW-1:0] entry_idx,
    input logic          scan_end,
    input logic          wr_reject
);

    logic acc;
    assign acc = running && conv_req && !start;

    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (!running && entry_idx == '0 && !scan_end && !wr_reject && mux_sel == 4'd0));

    p_hold_r4: assert property (@(posedge clk) disable iff (rst)
        !acc |=> ($stable(mux_sel) && $stable(gain_sel) && $stable(entry_idx)));

    p_end_after_strobe_r6: assert property (@(posedge clk) disable iff (rst)
        scan_end |-> $past(acc));

    p_start_arms_r7: assert property (@(posedge clk) disable iff (rst)
        start |=> running);

    p_busy_write_flag_r8: assert property (@(posedge clk) disable iff (rst)
        (running && (wr_en || len_we)) |=> wr_reject);

    p_gain_unity_r10: assert property (@(posedge clk) disable iff (rst)
        (gain_sel == 2'd0) |-> (gain_mult == 10'd1));

endmodule

bind scan_list_seq scan_list_seq_chk #(.AW(AW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .len_we    (len_we),
    .start     (start),
    .conv_req  (conv_req),
    .running   (running),
    .mux_sel   (mux_sel),
    .gain_sel  (gain_sel),
    .gain_mult (gain_mult),
    .entry_idx (entry_idx),
    .scan_end  (scan_end),
    .wr_reject (wr_reject)
);

// File: tb/sim_scan_list_seq.sv
`timescale 1ns/100ps
module sim_scan_list_seq;

    localparam int DEPTH = 64;
    localparam int AW    = $clog2(DEPTH);

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic          rst = 1'b1;
    logic          wr_en = 1'b0, len_we = 1'b0, start = 1'b0, stop = 1'b0, conv_req = 1'b0;
    logic [AW-1:0] wr_addr = '0, len_last = '0;
    logic [3:0]    wr_chan = '0;
    logic [1:0]    wr_gain = '0;

    logic          running, scan_end, wr_reject;
    logic [3:0]    mux_sel;
    logic [1:0]    gain_sel;
    logic [9:0]    gain_mult;
    logic [AW-1:0] entry_idx;

    logic          running1, scan_end1, wr_reject1;
    logic [3:0]    mux_sel1;
    logic [1:0]    gain_sel1;
    logic [9:0]    gain_mult1;
    logic [AW-1:0] entry_idx1;

    scan_list_seq #(.LIST_DEPTH(DEPTH), .LOW_RANGE(1'b0)) u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_chan(wr_chan),
        .wr_gain(wr_gain), .len_we(len_we), .len_last(len_last), .start(start),
        .stop(stop), .conv_req(conv_req), .running(running), .mux_sel(mux_sel),
        .gain_sel(gain_sel), .gain_mult(gain_mult), .entry_idx(entry_idx),
        .scan_end(scan_end), .wr_reject(wr_reject)
    );

    scan_list_seq #(.LIST_DEPTH(DEPTH), .LOW_RANGE(1'b1)) u1 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_chan(wr_chan),
        .wr_gain(wr_gain), .len_we(len_we), .len_last(len_last), .start(start),
        .stop(stop), .conv_req(conv_req), .running(running1), .mux_sel(mux_sel1),
        .gain_sel(gain_sel1), .gain_mult(gain_mult1), .entry_idx(entry_idx1),
        .scan_end(scan_end1), .wr_reject(wr_reject1)
    );

    int n_chk = 0;
    int n_bad = 0;
    int exp_ch [DEPTH];
    int exp_g  [DEPTH];
    int exp_last = 0;

    task automatic chk(input string req, input int act, input int expv);
        n_chk++;
        if (act != expv) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    function automatic int hi_mult(input int g);
        return 1 << g;
    endfunction

    function automatic int lo_mult(input int g);
        case (g)
            0: return 1;
            1: return 10;
            2: return 100;
            default: return 500;
        endcase
    endfunction

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic put_entry(input int a, input int ch, input int g);
        wr_en = 1'b1; wr_addr = AW'(a); wr_chan = 4'(ch); wr_gain = 2'(g);
        tick();
        wr_en = 1'b0;
    endtask

    task automatic set_last(input int v);
        len_we = 1'b1; len_last = AW'(v);
        tick();
        len_we = 1'b0;
    endtask

    task automatic go();
        start = 1'b1; tick(); start = 1'b0;
    endtask

    task automatic halt();
        stop = 1'b1; tick(); stop = 1'b0;
    endtask

    task automatic strobe();
        conv_req = 1'b1; tick(); conv_req = 1'b0;
    endtask

    task automatic expect_entry(input string req, input int idx);
        chk({req, " index"}, int'(entry_idx), idx);
        chk({req, " channel"}, int'(mux_sel), exp_ch[idx]);
        chk({req, " gain code"}, int'(gain_sel), exp_g[idx]);
        chk("R6 end marker", int'(scan_end), (idx == exp_last) ? 1 : 0);
        chk("R10 high gain factor", int'(gain_mult), hi_mult(exp_g[idx]));
        chk("R10 low gain factor", int'(gain_mult1), lo_mult(exp_g[idx]));
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) tick();
        chk("R1 running in reset", int'(running), 0);
        chk("R1 index in reset", int'(entry_idx), 0);
        rst = 1'b0;
        tick();
        chk("R1 mux after reset", int'(mux_sel), 0);
        chk("R1 gain after reset", int'(gain_sel), 0);
        chk("R1 end after reset", int'(scan_end), 0);
        chk("R1 reject after reset", int'(wr_reject), 0);
    endtask

    task automatic t_load_scan();
        int chs [6] = '{3, 7, 3, 0, 15, 9};
        int gs  [6] = '{0, 1, 3, 2, 1, 0};
        for (int i = 0; i < 6; i++) begin
            put_entry(i, chs[i], gs[i]);
            exp_ch[i] = chs[i];
            exp_g[i]  = gs[i];
            chk("R8 no reject when stopped", int'(wr_reject), 0);
        end
        set_last(5);
        exp_last = 5;
        go();
        chk("R7 running after start", int'(running), 1);
        for (int i = 0; i < 6; i++) begin
            strobe();
            expect_entry("R3 R11 scan", i);
        end
        tick();
        chk("R6 end marker drops", int'(scan_end), 0);
        strobe();
        expect_entry("R5 wrap", 0);
    endtask

    task automatic t_hold();
        int idx0 = int'(entry_idx);
        int ch0  = int'(mux_sel);
        int g0   = int'(gain_sel);
        repeat (4) tick();
        chk("R4 index hold", int'(entry_idx), idx0);
        chk("R4 channel hold", int'(mux_sel), ch0);
        chk("R4 gain hold", int'(gain_sel), g0);
    endtask

    task automatic t_busy_write();
        int idx0;
        put_entry(1, 12, 3);
        chk("R8 reject on list write", int'(wr_reject), 1);
        tick();
        chk("R8 reject one cycle", int'(wr_reject), 0);
        set_last(2);
        chk("R8 reject on length write", int'(wr_reject), 1);
        halt();
        chk("R12 stopped", int'(running), 0);
        idx0 = int'(entry_idx);
        strobe();
        chk("R9 idle strobe index", int'(entry_idx), idx0);
        chk("R9 idle strobe channel", int'(mux_sel), exp_ch[idx0]);
        go();
        for (int i = 0; i < 6; i++) begin
            strobe();
            expect_entry("R8 list unchanged", i);
        end
    endtask

    task automatic t_restart();
        strobe(); strobe(); strobe();
        expect_entry("R3 before restart", 2);
        start = 1'b1; conv_req = 1'b1;
        tick();
        start = 1'b0; conv_req = 1'b0;
        chk("R7 same-cycle strobe dropped", int'(entry_idx), 2);
        strobe();
        expect_entry("R7 restart at zero", 0);
    endtask

    task automatic t_stopped_write();
        halt();
        put_entry(4, 5, 2);
        exp_ch[4] = 5; exp_g[4] = 2;
        chk("R8 stopped write accepted", int'(wr_reject), 0);
        go();
        for (int i = 0; i < 5; i++) strobe();
        expect_entry("R2 written entry", 4);
    endtask

    task automatic t_one_entry();
        halt();
        set_last(0);
        exp_last = 0;
        go();
        strobe();
        expect_entry("R5 one-entry list", 0);
        strobe();
        expect_entry("R5 one-entry repeat", 0);
    endtask

    initial begin
        t_reset();
        t_load_scan();
        t_hold();
        t_busy_write();
        t_restart();
        t_stopped_write();
        t_one_entry();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule